// File: doc/BRIEF.md
# Seven-Level Stacked-Carrier PWM Gate Generator

This block drives the switches of a seven-level single-phase inverter. The power stage is three cascaded cells and an output H-bridge. Each cell has a series switch, which adds its DC source to the staircase, and a bypass switch, which shorts the cell out. The H-bridge then unfolds the unipolar staircase into an AC waveform. Inside the block, a phase counter steps through a quarter-wave sine table to make a rectified 50 Hz reference. That reference is compared against three triangular carriers. The carriers share one phase, and each sits in its own quarter of the 12-bit amplitude range.

Each comparison gives the on/off demand for one cell. The cell's series and bypass switches are driven as a complementary pair, with a programmable blanking gap on every turn-on. The sign of the reference picks which bridge diagonal conducts, and the bridge uses the same blanking gap. With the 4.096 MHz clock the defaults assume, the reference runs at 50 Hz and the carriers at 2 kHz. Software supplies the dead time and a run enable. While the block is not running, every gate is held low.

Top module: `mlpwm_gen`

## Requirements
- R1: While rst_n is low, and in the cycle after any clock edge sampled with en low, all ten gate outputs are 0.
- R2: The reference magnitude is taken from a 64-entry quarter-wave table. Entry i holds floor(65520*x*(256-x) / (327680 - 4*x*(256-x))) with x = 2i+1. A phase index idx (0..255) advances once every 320 clocks and wraps to 0. In quadrants 1 and 3 (idx bit 6 set), the table is read at 63-(idx mod 64); otherwise it is read at idx mod 64. After reset, idx is 0.
- R3: One triangle counter t counts clocks modulo 2048 starting from reset. The shared carrier value is c = t for t < 1024, and c = 2047 - t otherwise. Cell k (k = 0, 1, 2) compares against 1024*(k+1) + c.
- R4: The demand of cell k is high exactly when the magnitude is strictly greater than that cell's carrier. unit_gate bit 2k is the series switch of cell k.
- R5: Once settled, unit_gate bit 2k+1 (the bypass switch of cell k) is the inverse of bit 2k.
- R6: When a pair's demand changes under a nonzero dead_cyc D, both of its switches are low for exactly D cycles, and then the new state is driven. With D = 0, the pair swaps in the cycle after the change. D is read at the change.
- R7: The series and bypass switches of one cell are never high together.
- R8: When idx < 128, the positive diagonal (bridge_gate bits 0 and 3) conducts. When idx >= 128, the negative diagonal (bits 1 and 2) conducts. A change occurs only where idx crosses 127/128 or 255/0, and it is subject to the same dead time as R6.
- R9: The two bridge diagonals are never high together.
- R10: While the magnitude is below 1024, all series switches are low and, once settled, all bypass switches are high (zero output level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4.096 MHz for 50 Hz output) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces all gates off |
| dead_cyc | input | 8 | Blanking gap in clock cycles applied on every turn-on |
| unit_gate | output | 6 | Cell gates: bit 2k series, bit 2k+1 bypass of cell k |
| bridge_gate | output | 4 | Bridge gates: bits 0,3 positive diagonal, bits 1,2 negative |

## Verification
The bench goes after the points where the waveform folds: the zero crossing, where a bridge that switched early or without a gap would short the staircase, and the quadrant turn, where a wrong mirror address would show a step or a double peak in the pulse pattern. It measures every blanking gap on cell 0 under a nonzero dead time. A gap that is one cycle off, or a pair that swaps with no gap, shows up as a length mismatch. It also runs with a zero dead time, where a design that still blanked for a cycle would drop both switches. Enable and mid-run reset are toggled to catch gates that stay on or carriers that lose their phase.

// File: rtl/mlpwm_gen.sv
module mlpwm_gen #(
  parameter int QW_BITS     = 6,
  parameter int ENTRY_TICKS = 320,
  parameter int DT_BITS     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [DT_BITS-1:0] dead_cyc,
  output logic [5:0]         unit_gate,
  output logic [3:0]         bridge_gate
);
  localparam int MAG_W = 12;
  localparam int TRI_W = MAG_W - 1;
  localparam int IDX_W = QW_BITS + 2;
  localparam int QN    = 1 << QW_BITS;
  localparam int SUB_W = $clog2(ENTRY_TICKS);

  function automatic logic [QN*MAG_W-1:0] build_rom();
    logic [QN*MAG_W-1:0] r;
    longint p, fs, x, num, den;
    r  = '0;
    p  = longint'(1) << (QW_BITS + 2);
    fs = (longint'(1) << MAG_W) - 1;
    for (int i = 0; i < QN; i++) begin
      x   = 2 * i + 1;
      num = 16 * fs * x * (p - x);
      den = 5 * p * p - 4 * x * (p - x);
      r[i*MAG_W +: MAG_W] = MAG_W'(num / den);
    end
    return r;
  endfunction

  localparam logic [QN*MAG_W-1:0] ROM = build_rom();

  logic [IDX_W-1:0]   idx;
  logic [SUB_W-1:0]   sub;
  logic [TRI_W-1:0]   tri_t;
  logic [QW_BITS-1:0] addr;
  logic [MAG_W-1:0]   mag;
  logic [TRI_W-2:0]   car;
  logic [3:0]         want, s_on, b_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx   <= '0;
      sub   <= '0;
      tri_t <= '0;
    end else begin
      tri_t <= tri_t + 1'b1;
      if (sub == SUB_W'(ENTRY_TICKS - 1)) begin
        sub <= '0;
        idx <= idx + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end

  assign addr = idx[QW_BITS] ? ~idx[QW_BITS-1:0] : idx[QW_BITS-1:0];
  assign mag  = ROM[addr*MAG_W +: MAG_W];
  assign car  = tri_t[TRI_W-1] ? ~tri_t[TRI_W-2:0] : tri_t[TRI_W-2:0];

  for (genvar k = 0; k < 3; k++) begin : g_cmp
    assign want[k] = mag > {2'(k + 1), car};
  end
  assign want[3] = idx[IDX_W-1];

  for (genvar k = 0; k < 4; k++) begin : g_pair
    logic               cur_q, s_q, b_q;
    logic [DT_BITS-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n || !en) begin
        cur_q <= 1'b0;
        cnt_q <= '0;
        s_q   <= 1'b0;
        b_q   <= 1'b0;
      end else if (want[k] != cur_q) begin
        cur_q <= want[k];
        if (dead_cyc == '0) begin
          s_q   <= want[k];
          b_q   <= ~want[k];
          cnt_q <= '0;
        end else begin
          s_q   <= 1'b0;
          b_q   <= 1'b0;
          cnt_q <= dead_cyc - 1'b1;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        s_q   <= 1'b0;
        b_q   <= 1'b0;
      end else begin
        s_q <= cur_q;
        b_q <= ~cur_q;
      end
    assign s_on[k] = s_q;
    assign b_on[k] = b_q;
  end

  assign unit_gate   = {b_on[2], s_on[2], b_on[1], s_on[1], b_on[0], s_on[0]};
  assign bridge_gate = {b_on[3], s_on[3], s_on[3], b_on[3]};
endmodule

// File: rtl/mlpwm_gen_chk.sv
module mlpwm_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [7:0] dead_cyc,
  input logic [5:0] unit_gate,
  input logic [3:0] bridge_gate
);
  p_unit_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(unit_gate[0] && unit_gate[1]) && !(unit_gate[2] && unit_gate[3]) && !(unit_gate[4] && unit_gate[5]));

  p_bridge_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !((bridge_gate[0] || bridge_gate[3]) && (bridge_gate[1] || bridge_gate[2])));

  p_idle_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (unit_gate == 6'd0 && bridge_gate == 4'd0));

  p_unit_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(unit_gate[0]) && $past(dead_cyc) != 8'd0) |-> !unit_gate[1]);

  p_bridge_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bridge_gate[0]) && $past(dead_cyc) != 8'd0) |-> !bridge_gate[1]);
endmodule

bind mlpwm_gen mlpwm_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dead_cyc(dead_cyc),
  .unit_gate(unit_gate), .bridge_gate(bridge_gate)
);

// File: tb/mlpwm_gen_bench.sv
module mlpwm_gen_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] dead_cyc = 8'd5;
  logic [5:0] unit_gate;
  logic [3:0] bridge_gate;

  int vectors = 0, errors = 0;
  longint n = 0;
  int m_cur[4], m_cnt[4], m_s[4], m_b[4];
  logic [5:0] exp_u;
  logic [3:0] exp_br;
  int gap = 0, gaps_seen = 0;
  bit seen_on = 0, done = 0;

  mlpwm_gen u_mlpwm_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .dead_cyc(dead_cyc),
    .unit_gate(unit_gate), .bridge_gate(bridge_gate)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic int ref_mag(longint cyc);
    longint idx, a, x;
    idx = (cyc / 320) % 256;
    a = idx % 64;
    if (((idx / 64) % 2) == 1) a = 63 - a;
    x = 2 * a + 1;
    return int'((65520 * x * (256 - x)) / (327680 - 4 * x * (256 - x)));
  endfunction

  function automatic int ref_car(longint cyc);
    longint t;
    t = cyc % 2048;
    return (t < 1024) ? int'(t) : int'(2047 - t);
  endfunction

  task automatic model_step();
    int d[4];
    int mg, cr;
    if (!rst_n) begin
      n = 0;
      for (int k = 0; k < 4; k++) begin m_cur[k] = 0; m_cnt[k] = 0; m_s[k] = 0; m_b[k] = 0; end
    end else begin
      mg = ref_mag(n);
      cr = ref_car(n);
      for (int k = 0; k < 3; k++) d[k] = (mg > 1024 * (k + 1) + cr) ? 1 : 0;
      d[3] = (((n / 320) % 256) >= 128) ? 1 : 0;
      for (int k = 0; k < 4; k++) begin
        if (!en) begin
          m_cur[k] = 0; m_cnt[k] = 0; m_s[k] = 0; m_b[k] = 0;
        end else if (d[k] != m_cur[k]) begin
          m_cur[k] = d[k];
          if (dead_cyc == 0) begin m_s[k] = d[k]; m_b[k] = 1 - d[k]; m_cnt[k] = 0; end
          else begin m_s[k] = 0; m_b[k] = 0; m_cnt[k] = int'(dead_cyc) - 1; end
        end else if (m_cnt[k] != 0) begin
          m_cnt[k]--; m_s[k] = 0; m_b[k] = 0;
        end else begin
          m_s[k] = m_cur[k]; m_b[k] = 1 - m_cur[k];
        end
      end
      n++;
    end
    for (int k = 0; k < 3; k++) begin exp_u[2*k] = m_s[k][0]; exp_u[2*k+1] = m_b[k][0]; end
    exp_br = {m_b[3][0], m_s[3][0], m_s[3][0], m_b[3][0]};
  endtask

  task automatic chk_u(string tag, logic [5:0] exp);
    vectors++;
    if (unit_gate !== exp) begin
      errors++;
      $display("FAIL %s unit_gate got %b exp %b at n=%0d", tag, unit_gate, exp, n);
    end
  endtask

  task automatic chk_b(string tag, logic [3:0] exp);
    vectors++;
    if (bridge_gate !== exp) begin
      errors++;
      $display("FAIL %s bridge_gate got %b exp %b at n=%0d", tag, bridge_gate, exp, n);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    model_step();
    chk_u(en ? "R2 R3 R4 R5 R6 R10" : "R1", exp_u);
    chk_b(en ? "R8" : "R1", exp_br);
    vectors++;
    if ((unit_gate[0] && unit_gate[1]) || (unit_gate[2] && unit_gate[3]) ||
        (unit_gate[4] && unit_gate[5]) || (bridge_gate[0] && bridge_gate[1])) begin
      errors++;
      $display("FAIL R7 R9 overlap got %b/%b exp no pair high", unit_gate, bridge_gate);
    end
    if (!en || !rst_n) begin
      seen_on = 0; gap = 0;
    end else if (!unit_gate[0] && !unit_gate[1]) begin
      if (seen_on) gap++;
    end else begin
      if (gap > 0) begin
        gaps_seen++; vectors++;
        if (gap != int'(dead_cyc)) begin
          errors++;
          $display("FAIL R6 gap got %0d exp %0d", gap, dead_cyc);
        end
      end
      gap = 0; seen_on = 1;
    end
    // directed points, counted by model index after the step
    if (en && dead_cyc == 8'd5) begin
      if (n == 1601) chk_u("R10", 6'b101010);
      if (n == 20161) begin chk_u("R2 R4", 6'b010101); chk_b("R8", 4'b1001); end
      if (n == 48001) begin chk_u("R3 R4 R5", 6'b101001); chk_b("R8", 4'b0110); end
    end
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) cycle();
    chk_u("R1", 6'd0); chk_b("R1", 4'd0);
    rst_n = 1'b1; en = 1'b1; dead_cyc = 8'd5;
    repeat (90000) cycle();
    vectors++;
    if (gaps_seen == 0) begin
      errors++;
      $display("FAIL R6 gap count got 0 exp >0");
    end
    en = 1'b0;
    repeat (20) cycle();
    chk_u("R1", 6'd0); chk_b("R1", 4'd0);
    dead_cyc = 8'd0; en = 1'b1;
    repeat (20000) cycle();
    rst_n = 1'b0;
    repeat (4) cycle();
    chk_u("R1", 6'd0); chk_b("R1", 4'd0);
    rst_n = 1'b1; dead_cyc = 8'd3;
    repeat (5000) cycle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule